// File: doc/BRIEF.md
# Multi-mode PCM serial port

This block is a single-slot serial voice port. In each frame it moves one PCM sample from a serial data input into a parallel word, and one parallel word out onto a serial data output. Each direction carries either an 8-bit companded sample or a 16-bit linear two's complement sample, and the two directions choose their widths independently. A completed receive word is presented with a one-cycle valid strobe.

The port supports three framing schemes and picks one from the frame input alone. A short low pulse on an otherwise high frame line selects pulse-framed operation with an active-low sync. A short high pulse on an otherwise low line selects pulse-framed operation with an active-high sync. In both pulse-framed schemes every data bit spans two bit-clock periods, and the slot opens on the first bit-clock rise after the pulse ends. A frame line that shows no change for two frame periods selects strobed operation. In strobed operation each bit-clock period carries one bit, and each direction shifts only while its own enable is high.

All port pins are sampled in the system clock domain through synchronizer stages. The bit clock is oversampled, so transmit data changes after a bit-clock rise and receive data is captured at a bit-clock fall.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, sd_o is 0, rx_valid_o is 0 and mode_o is 0, which is the strobed encoding. mode_o uses 0 for strobed, 1 for active-low pulse framing and 2 for active-high pulse framing.
- R2: A low pulse on fp_i, lasting fewer than PULSE_MAX bit-clock rises and preceded by at least PULSE_MAX rises at high, sets mode_o to 1. The slot then starts at the first rise where fp_i is seen high again.
- R3: A high pulse on fp_i, lasting fewer than PULSE_MAX rises and preceded by at least PULSE_MAX rises at low, sets mode_o to 2, with the same slot start rule as R2.
- R4: Once fp_i has held one level for 2*FRAME_BCLKS bit-clock rises since its last change, mode_o becomes 0 at that rise and no earlier.
- R5: In pulse-framed modes, sd_o sends the transmit word MSB first. Each bit is held for two bit-clock periods and changes only after a rise. The word is latched at the slot's first rise. sd_o returns to 0 after the last bit.
- R6: In pulse-framed modes, receive bit k is taken at the fall that follows slot rise 2k+1. After the last bit, rx_valid_o is high for exactly one system clock with the word on rx_data_o.
- R7: In strobed mode, sd_o sends one bit per bit-clock period, MSB first, starting at the first rise with en_tx_i high. It is 0 at any rise where en_tx_i is low.
- R8: In strobed mode, receive bits are taken at falls where en_rx_i is high. A partial word is discarded at a fall where en_rx_i is low, and no strobe is raised for it.
- R9: The width for each direction is chosen separately: a wide input of 1 means 16 bits and 0 means 8 bits. An 8-bit transmit word is taken from tx_data_i[7:0]. An 8-bit receive word appears zero-extended in rx_data_o[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the bit clock |
| rst_ni | input | 1 | Active-low reset |
| bclk_i | input | 1 | Bit clock from the serial bus |
| fp_i | input | 1 | Frame input; its behaviour selects the framing mode |
| en_tx_i | input | 1 | Strobed-mode transmit enable |
| en_rx_i | input | 1 | Strobed-mode receive enable |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |
| tx_wide_i | input | 1 | Transmit width: 1 selects 16 bits, 0 selects 8 bits |
| tx_data_i | input | LIN_W | Transmit sample, latched at slot start |
| rx_wide_i | input | 1 | Receive width: 1 selects 16 bits, 0 selects 8 bits |
| rx_data_o | output | LIN_W | Last completed receive sample |
| rx_valid_o | output | 1 | One-cycle strobe for a new receive sample |
| mode_o | output | 2 | Current framing mode (0 strobed, 1 active-low pulse, 2 active-high pulse) |

## Verification
A wrong mode register shows up within one frame. The slot never opens, so sd_o stays 0 for the whole frame and no receive strobe appears. An off-by-one error in either bit counter moves the receive strobe by one bit-clock period and shifts the returned word, so it is visible at the first sample of each width. A stuck silence counter surfaces two frame periods after the last frame-line change, because mode_o then fails to fall back to the strobed encoding at that exact rise.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

   typedef enum logic [1:0] {
      MODE_STROBED    = 2'd0,
      MODE_PULSE_LOW  = 2'd1,
      MODE_PULSE_HIGH = 2'd2
   } pcm_mode_e;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
   parameter int unsigned N           = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] sync_o,
   output logic         rise_o,
   output logic         fall_o
);

   logic [N-1:0] stage_q [SYNC_STAGES];
   logic         bclk_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= async_i;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_prev_q <= 1'b0;
      else        bclk_prev_q <= sync_o[0];
   end

   assign rise_o = sync_o[0] & ~bclk_prev_q;
   assign fall_o = ~sync_o[0] & bclk_prev_q;

endmodule

// File: rtl/pcm_frame_detect.sv
module pcm_frame_detect
   import pcm_port_pkg::*;
#(
   parameter int unsigned FRAME_BCLKS = 512,
   parameter int unsigned PULSE_MAX   = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick_rise,
   input  logic      fp_s,
   output pcm_mode_e mode_o,
   output logic      frame_start_o
);

   localparam int unsigned TMO = 2 * FRAME_BCLKS;
   localparam int unsigned CW  = $clog2(TMO + 1);
   localparam logic [CW-1:0] TMO_C   = CW'(TMO);
   localparam logic [CW-1:0] PULSE_C = CW'(PULSE_MAX);

   logic      fp_prev_q;
   logic [CW-1:0] cnt_q;
   pcm_mode_e mode_q;
   logic      fp_edge;
   logic      pulse_end;

   assign fp_edge   = tick_rise && (fp_s != fp_prev_q);
   assign pulse_end = fp_edge && (cnt_q < PULSE_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fp_prev_q <= 1'b0;
         cnt_q     <= TMO_C;
         mode_q    <= MODE_STROBED;
      end else if (tick_rise) begin
         fp_prev_q <= fp_s;
         if (fp_edge) begin
            cnt_q <= '0;
            if (pulse_end) mode_q <= fp_s ? MODE_PULSE_LOW : MODE_PULSE_HIGH;
         end else if (cnt_q != TMO_C) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == TMO_C - 1'b1) mode_q <= MODE_STROBED;
         end
      end
   end

   assign mode_o        = mode_q;
   assign frame_start_o = pulse_end;

   AST_PULSE_SETS_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> (mode_q != MODE_STROBED)); // R2

   AST_SILENCE_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_rise && !fp_edge && cnt_q == TMO_C - 1'b1) |=> (mode_q == MODE_STROBED)); // R4

   AST_MODE_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q inside {MODE_STROBED, MODE_PULSE_LOW, MODE_PULSE_HIGH}); // R1

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
   parameter int unsigned LIN_W = 16,
   parameter int unsigned CMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_rise,
   input  logic             framed,
   input  logic             frame_start,
   input  logic             en_s,
   input  logic             wide_i,
   input  logic [LIN_W-1:0] data_i,
   output logic             sd_o
);

   localparam int unsigned BW = $clog2(LIN_W + 1);

   logic [LIN_W-1:0] shift_q;
   logic [BW-1:0]    left_q;
   logic             hold_q;
   logic             busy_q;
   logic             sd_q;
   logic [LIN_W-1:0] word;
   logic [BW-1:0]    nbits;
   logic             load_slot;

   assign word      = wide_i ? data_i : {data_i[CMP_W-1:0], {(LIN_W-CMP_W){1'b0}}};
   assign nbits     = wide_i ? BW'(LIN_W) : BW'(CMP_W);
   assign load_slot = tick_rise && (frame_start || (!framed && en_s && !busy_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         left_q  <= '0;
         hold_q  <= 1'b0;
         busy_q  <= 1'b0;
         sd_q    <= 1'b0;
      end else if (load_slot) begin
         shift_q <= word << 1;
         sd_q    <= word[LIN_W-1];
         left_q  <= nbits - 1'b1;
         hold_q  <= frame_start;
         busy_q  <= !frame_start;
      end else if (tick_rise) begin
         if (framed) begin
            if (hold_q) begin
               hold_q <= 1'b0;
            end else if (left_q != '0) begin
               sd_q    <= shift_q[LIN_W-1];
               shift_q <= shift_q << 1;
               left_q  <= left_q - 1'b1;
               hold_q  <= 1'b1;
            end else begin
               sd_q <= 1'b0;
            end
         end else begin
            hold_q <= 1'b0;
            if (!en_s) begin
               busy_q <= 1'b0;
               sd_q   <= 1'b0;
            end else if (left_q != '0) begin
               sd_q    <= shift_q[LIN_W-1];
               shift_q <= shift_q << 1;
               left_q  <= left_q - 1'b1;
            end else begin
               sd_q <= 1'b0;
            end
         end
      end
   end

   assign sd_o = sd_q;

   AST_TX_CHANGES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_rise |=> $stable(sd_q)); // R5

   AST_TX_SILENT_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_rise && !framed && !frame_start && !en_s) |=> !sd_q); // R7

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
   parameter int unsigned LIN_W = 16,
   parameter int unsigned CMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_rise,
   input  logic             tick_fall,
   input  logic             framed,
   input  logic             frame_start,
   input  logic             en_s,
   input  logic             wide_i,
   input  logic             sd_s,
   output logic [LIN_W-1:0] data_o,
   output logic             valid_o
);

   localparam int unsigned BW = $clog2(LIN_W + 1);

   logic [LIN_W-2:0] shift_q;
   logic [BW-1:0]    got_q;
   logic             armed_q;
   logic             phase_q;
   logic             wide_q;
   logic [LIN_W-1:0] data_q;
   logic             valid_q;
   logic [LIN_W-1:0] nxt;
   logic             use_wide;
   logic [BW-1:0]    need;
   logic             take;
   logic             last;

   assign nxt      = {shift_q, sd_s};
   assign use_wide = (!framed && got_q == '0) ? wide_i : wide_q;
   assign need     = use_wide ? BW'(LIN_W) : BW'(CMP_W);
   assign take     = tick_fall && (framed ? (armed_q && phase_q) : en_s);
   assign last     = take && (got_q == need - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         got_q   <= '0;
         armed_q <= 1'b0;
         phase_q <= 1'b0;
         wide_q  <= 1'b0;
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (tick_rise) begin
            if (frame_start) begin
               armed_q <= 1'b1;
               got_q   <= '0;
               phase_q <= 1'b0;
               wide_q  <= wide_i;
            end else begin
               phase_q <= ~phase_q;
            end
         end
         if (tick_fall && !framed && !en_s) got_q <= '0;
         if (take) begin
            shift_q <= nxt[LIN_W-2:0];
            if (!framed && got_q == '0) wide_q <= wide_i;
            if (last) begin
               valid_q <= 1'b1;
               data_q  <= use_wide ? nxt : {{(LIN_W-CMP_W){1'b0}}, nxt[CMP_W-1:0]};
               got_q   <= '0;
               if (framed) armed_q <= 1'b0;
            end else begin
               got_q <= got_q + 1'b1;
            end
         end
      end
   end

   assign data_o  = data_q;
   assign valid_o = valid_q;

   AST_RX_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q); // R6

   AST_RX_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $past(tick_fall)); // R8

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
   import pcm_port_pkg::*;
#(
   parameter int unsigned LIN_W       = 16,
   parameter int unsigned CMP_W       = 8,
   parameter int unsigned FRAME_BCLKS = 512,
   parameter int unsigned PULSE_MAX   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bclk_i,
   input  logic             fp_i,
   input  logic             en_tx_i,
   input  logic             en_rx_i,
   input  logic             sd_i,
   output logic             sd_o,
   input  logic             tx_wide_i,
   input  logic [LIN_W-1:0] tx_data_i,
   input  logic             rx_wide_i,
   output logic [LIN_W-1:0] rx_data_o,
   output logic             rx_valid_o,
   output logic [1:0]       mode_o
);

   localparam int unsigned NSYNC = 5;

   if (CMP_W == 0 || CMP_W >= LIN_W) begin : g_bad_width
      $error("pcm_serial_port: CMP_W must be nonzero and below LIN_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pcm_serial_port: SYNC_STAGES must be at least 2");
   end
   if (PULSE_MAX < 1 || FRAME_BCLKS < 2 * LIN_W + PULSE_MAX + 2) begin : g_bad_frame
      $error("pcm_serial_port: frame too short for the slot and pulse");
   end

   logic [NSYNC-1:0] pins_s;
   logic             tick_rise;
   logic             tick_fall;
   pcm_mode_e        mode;
   logic             frame_start;
   logic             framed;

   pcm_edge_sync #(
      .N           (NSYNC),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_sync (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .async_i ({sd_i, en_rx_i, en_tx_i, fp_i, bclk_i}),
      .sync_o  (pins_s),
      .rise_o  (tick_rise),
      .fall_o  (tick_fall)
   );

   pcm_frame_detect #(
      .FRAME_BCLKS (FRAME_BCLKS),
      .PULSE_MAX   (PULSE_MAX)
   ) i_detect (
      .clk           (clk_i),
      .rst_n         (rst_ni),
      .tick_rise     (tick_rise),
      .fp_s          (pins_s[1]),
      .mode_o        (mode),
      .frame_start_o (frame_start)
   );

   assign framed = (mode != MODE_STROBED);

   pcm_tx_shift #(
      .LIN_W (LIN_W),
      .CMP_W (CMP_W)
   ) i_tx (
      .clk         (clk_i),
      .rst_n       (rst_ni),
      .tick_rise   (tick_rise),
      .framed      (framed),
      .frame_start (frame_start),
      .en_s        (pins_s[2]),
      .wide_i      (tx_wide_i),
      .data_i      (tx_data_i),
      .sd_o        (sd_o)
   );

   pcm_rx_shift #(
      .LIN_W (LIN_W),
      .CMP_W (CMP_W)
   ) i_rx (
      .clk         (clk_i),
      .rst_n       (rst_ni),
      .tick_rise   (tick_rise),
      .tick_fall   (tick_fall),
      .framed      (framed),
      .frame_start (frame_start),
      .en_s        (pins_s[3]),
      .wide_i      (rx_wide_i),
      .sd_s        (pins_s[4]),
      .data_o      (rx_data_o),
      .valid_o     (rx_valid_o)
   );

   assign mode_o = mode;

endmodule

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;

   localparam int FRAME = 64;
   localparam int TMO   = 2 * FRAME;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0, fp = 1'b0, en_tx = 1'b0, en_rx = 1'b0, sd_in = 1'b0;
   logic        sd_out;
   logic        tx_wide = 1'b1, rx_wide = 1'b1;
   logic [15:0] tx_data = '0;
   logic [15:0] rx_data;
   logic        rx_valid;
   logic [1:0]  mode;

   int checks = 0, fails = 0, vcount = 0;
   logic [15:0] vdata = '0;
   bit done = 0;

   always #10 clk = ~clk;

   pcm_serial_port #(.FRAME_BCLKS(FRAME)) i_pcm_serial_port (
      .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fp_i(fp),
      .en_tx_i(en_tx), .en_rx_i(en_rx), .sd_i(sd_in), .sd_o(sd_out),
      .tx_wide_i(tx_wide), .tx_data_i(tx_data), .rx_wide_i(rx_wide),
      .rx_data_o(rx_data), .rx_valid_o(rx_valid), .mode_o(mode)
   );

   always @(negedge clk) if (rx_valid) begin vcount++; vdata = rx_data; end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic bit_clk(input logic fpv, input logic sdv, input logic etx, input logic erx);
      @(negedge clk);
      bclk = 1'b1; fp = fpv; sd_in = sdv; en_tx = etx; en_rx = erx;
      repeat (7) @(negedge clk);
      bclk = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      chk("R1", "sd_o", 32'(sd_out), 0);
      chk("R1", "rx_valid", 32'(rx_valid), 0);
      chk("R1", "mode", 32'(mode), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "mode after release", 32'(mode), 0);
   endtask

   task automatic framed_frame(input logic act, input logic [15:0] rxw, input bit rxwide,
                               input logic [15:0] txw, input bit txwide, input string rtag);
      int n_rx, n_tx, v0, hold_err;
      logic [15:0] got, exp_tx, exp_rx;
      logic first;
      n_rx = rxwide ? 16 : 8;
      n_tx = txwide ? 16 : 8;
      got = '0; hold_err = 0; first = 1'b0;
      tx_wide = txwide; tx_data = txw; rx_wide = rxwide;
      repeat (5) bit_clk(~act, 1'b0, 1'b0, 1'b0);
      v0 = vcount;
      bit_clk(act, 1'b0, 1'b0, 1'b0);
      for (int h = 0; h < 34; h++) begin
         int k;
         k = h / 2;
         bit_clk(~act, (k < n_rx) ? rxw[n_rx-1-k] : 1'b0, 1'b0, 1'b0);
         if (k < n_tx) begin
            if (h % 2 == 0) first = sd_out;
            else begin
               got = {got[14:0], sd_out};
               if (sd_out !== first) hold_err++;
            end
         end
      end
      exp_tx = txwide ? txw : {8'h00, txw[7:0]};
      exp_rx = rxwide ? rxw : {8'h00, rxw[7:0]};
      chk(rtag, "mode after pulse", 32'(mode), act ? 2 : 1);
      chk("R5", "framed tx word", 32'(got), 32'(exp_tx));
      chk("R5", "bit held two bclk", 32'(hold_err), 0);
      chk("R5", "sd_o idle after slot", 32'(sd_out), 0);
      chk("R6", "one strobe per frame", 32'(vcount - v0), 1);
      chk("R9", "framed rx word", 32'(vdata), 32'(exp_rx));
   endtask

   task automatic test_timeout();
      repeat (TMO - 1 - 33) bit_clk(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R4", "mode held one rise before limit", 32'(mode), 2);
      bit_clk(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R4", "mode strobed at limit", 32'(mode), 0);
   endtask

   task automatic ssi_word(input logic [15:0] rxw, input bit rxwide, input logic [15:0] txw, input bit txwide);
      int n_rx, n_tx, n, v0;
      logic [15:0] got, exp_tx, exp_rx;
      n_rx = rxwide ? 16 : 8;
      n_tx = txwide ? 16 : 8;
      n = (n_rx > n_tx) ? n_rx : n_tx;
      got = '0;
      tx_wide = txwide; tx_data = txw; rx_wide = rxwide;
      v0 = vcount;
      for (int i = 0; i < n + 2; i++) begin
         bit_clk(1'b0, (i < n_rx) ? rxw[n_rx-1-i] : 1'b0, i < n_tx, i < n_rx);
         if (i < n_tx) got = {got[14:0], sd_out};
         if (i == n_tx) chk("R7", "sd_o low when tx enable low", 32'(sd_out), 0);
      end
      exp_tx = txwide ? txw : {8'h00, txw[7:0]};
      exp_rx = rxwide ? rxw : {8'h00, rxw[7:0]};
      chk("R7", "strobed tx word", 32'(got), 32'(exp_tx));
      chk("R8", "one strobe per word", 32'(vcount - v0), 1);
      chk("R9", "strobed rx word", 32'(vdata), 32'(exp_rx));
   endtask

   task automatic test_disabled();
      int v0, errs;
      v0 = vcount; errs = 0;
      for (int i = 0; i < 20; i++) begin
         bit_clk(1'b0, i[0], 1'b0, 1'b0);
         if (sd_out !== 1'b0) errs++;
      end
      chk("R7", "sd_o quiet while disabled", 32'(errs), 0);
      chk("R8", "no strobe while disabled", 32'(vcount - v0), 0);
      for (int i = 0; i < 5; i++) bit_clk(1'b0, 1'b1, 1'b0, 1'b1);
      bit_clk(1'b0, 1'b0, 1'b0, 1'b0);
      bit_clk(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8", "partial word discarded", 32'(vcount - v0), 0);
      ssi_word(16'h00A5, 1'b0, 16'h003C, 1'b0);
      chk("R8", "only full word after abort", 32'(vcount - v0), 1);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      test_reset();
      framed_frame(1'b0, 16'hB3C5, 1'b1, 16'h9E71, 1'b1, "R2");
      framed_frame(1'b0, 16'h005A, 1'b0, 16'h8001, 1'b1, "R2");
      framed_frame(1'b1, 16'h00C3, 1'b0, 16'h00A6, 1'b0, "R3");
      framed_frame(1'b1, 16'h7F02, 1'b1, 16'h0081, 1'b0, "R3");
      test_timeout();
      ssi_word(16'hD00B, 1'b1, 16'h6A95, 1'b1);
      ssi_word(16'h0096, 1'b0, 16'hC33C, 1'b1);
      test_disabled();
      done = 1;
      finish_run();
   end

endmodule